// File: doc/BRIEF.md
# Timed Chip-Select Controller With Polarity Mask

This block holds the chip-select pins of a serial peripheral master. A start pulse supplies a new 8-bit chip-select pattern and a 2-bit delay code `t`. The block waits, writes the pattern into its logical chip-select register, waits again, and then raises a one-cycle done pulse so the instruction sequencer can move on. The logical pattern is active low: a 0 bit selects that device. Both waits are counted in module clock cycles. Each one lasts `t*(div+1)*2` cycles, where `div` is the prescaler value. The first wait also has a fixed two-cycle lead-in that the prescaler does not affect.

A separate polarity mask sets, pin by pin, whether the physical output is inverted. The mask acts only at the output. Every physical pin equals its logical bit XOR its mask bit. Software therefore writes the same logical patterns whatever the polarity of the attached devices. A mask load takes effect on the next clock, even while a chip-select sequence is running.

The sequencer has four states:
- `ST_IDLE` waits for a start.
- `ST_SETUP` counts the fixed two cycles.
- `ST_PRE` counts the wait before the update.
- `ST_POST` counts the wait after the update.

The transitions are:
- IDLE→SETUP on a start pulse.
- SETUP→PRE when the lead-in ends and the span is non-zero.
- SETUP→IDLE with the update and done at once when the span is zero.
- PRE→POST with the update.
- POST→IDLE with done.

Top module: `cs_timing_ctrl`

## Requirements
- R1: After reset every physical pin reads 1 (logical register 0xFF, mask 0x00) and `done_o` is 0.
- R2: The logical chip-select value is active low. With a zero mask the pins show exactly the pattern given at start, so pattern 0xFE drives only pin 0 low.
- R3: A start sampled at clock edge N updates the pins at edge N+2+t*(div+1)*2, and the pins do not change before that edge. `t` is the 2-bit delay code and `div` is the 8-bit prescaler value.
- R4: `done_o` rises at edge N+2+2*t*(div+1)*2. When t=0 it rises at the same edge as the pin update.
- R5: Each pin equals its logical bit XOR its mask bit. With logical 0xFE, mask 0xFF gives 0x01, mask 0x00 gives 0xFE and mask 0x01 gives 0xFF.
- R6: A mask load sampled at edge M changes the pins at edge M with no delay phase, whether idle or busy. It leaves the logical value untouched, and a later update is shown through the new mask.
- R7: A start pulse that arrives while a sequence is running is ignored. It causes no pin change and no extra done pulse.
- R8: The delay code, pattern and prescaler are captured at start. Changing `prescale_i` or `pattern_i` during a sequence has no effect on that sequence.
- R9: `done_o` is high for exactly one cycle per accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a chip-select update |
| delay_i | input | 2 | Delay code t |
| pattern_i | input | 8 | New logical chip-select pattern (active low) |
| mask_load_i | input | 1 | Strobe that loads the polarity mask |
| mask_i | input | 8 | Polarity mask, 1 inverts the pin |
| prescale_i | input | 8 | Prescaler value div |
| cs_pin_o | output | 8 | Physical chip-select pins |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench measures the exact edge of each pin change and done pulse across zero, small and maximal spans. A timer that is off by one, or that drops the fixed lead-in, shows up as an event a cycle early or late. It loads masks in the middle of a sequence and expects the later update to appear through the new mask. A design that applied the mask to the stored pattern, or that held the load until completion, would show a wrong value or a late edge. A second start and a prescaler change made while busy must leave no trace: no extra done pulse and no change to the timing.

// File: rtl/cs_ctrl_pkg.sv
package cs_ctrl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PRE,
        ST_POST
    } cs_state_e;

    localparam int FIXED_LEAD_CYC = 2;
endpackage

// File: rtl/cs_tick_timer.sv
module cs_tick_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R3
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i != '0) |=> !expired_o);
endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm
    import cs_ctrl_pkg::*;
#(
    parameter int CS_W  = 8,
    parameter int DLY_W = 2,
    parameter int DIV_W = 8,
    parameter int CNT_W = DLY_W + DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic [CS_W-1:0]  pattern_i,
    input  logic [DIV_W-1:0] prescale_i,
    input  logic             tmr_expired_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output logic             upd_o,
    output logic [CS_W-1:0]  upd_val_o,
    output logic             done_o
);
    cs_state_e        state_q, state_d;
    logic [DLY_W-1:0] t_q;
    logic [DIV_W-1:0] div_q;
    logic [CS_W-1:0]  pat_q;
    logic             done_q, done_d;
    logic [DIV_W:0]   div_plus_w;
    logic [CNT_W-1:0] prod_w, span_w, span_m1_w;

    assign div_plus_w = {1'b0, div_q} + 1'b1;
    assign prod_w     = CNT_W'(t_q) * CNT_W'(div_plus_w);
    assign span_w     = prod_w << 1;
    assign span_m1_w  = span_w - 1'b1;

    // state register and captured fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            t_q     <= '0;
            div_q   <= '0;
            pat_q   <= '1;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
            if (state_q == ST_IDLE && start_i) begin
                t_q   <= delay_i;
                div_q <= prescale_i;
                pat_q <= pattern_i;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_SETUP;
            ST_SETUP: if (tmr_expired_i) state_d = (span_w == '0) ? ST_IDLE : ST_PRE;
            ST_PRE:   if (tmr_expired_i) state_d = ST_POST;
            ST_POST:  if (tmr_expired_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        upd_o      = 1'b0;
        done_d     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    tmr_load_o = 1'b1;
                    tmr_val_o  = CNT_W'(FIXED_LEAD_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (tmr_expired_i) begin
                    if (span_w == '0) begin
                        upd_o  = 1'b1;
                        done_d = 1'b1;
                    end else begin
                        tmr_load_o = 1'b1;
                        tmr_val_o  = span_m1_w;
                    end
                end
            end
            ST_PRE: begin
                if (tmr_expired_i) begin
                    upd_o      = 1'b1;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = span_m1_w;
                end
            end
            ST_POST: begin
                if (tmr_expired_i) done_d = 1'b1;
            end
            default: ;
        endcase
    end

    assign upd_val_o = pat_q;
    assign done_o    = done_q;

    // R7
    busy_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(pat_q));
    // R8
    busy_prescale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(div_q) && $stable(t_q)));
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R4
    done_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POST && !tmr_expired_i) |=> !done_o);
endmodule

// File: rtl/cs_pin_stage.sv
module cs_pin_stage #(
    parameter int CS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_i,
    input  logic [CS_W-1:0] upd_val_i,
    input  logic            mask_load_i,
    input  logic [CS_W-1:0] mask_i,
    output logic [CS_W-1:0] pins_o
);
    logic [CS_W-1:0] log_q;
    logic [CS_W-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            log_q  <= '1;
            mask_q <= '0;
        end else begin
            if (upd_i)       log_q  <= upd_val_i;
            if (mask_load_i) mask_q <= mask_i;
        end
    end

    for (genvar g = 0; g < CS_W; g++) begin : g_pin
        assign pins_o[g] = log_q[g] ^ mask_q[g];
    end

    // R6
    mask_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_load_i |=> ((pins_o ^ log_q) == $past(mask_i)));
    // R3
    quiet_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_i && !mask_load_i) |=> $stable(pins_o));
    // R6
    mask_keeps_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_load_i && !upd_i) |=> $stable(log_q));
endmodule

// File: rtl/cs_timing_ctrl.sv
module cs_timing_ctrl #(
    parameter int CS_W  = 8,
    parameter int DLY_W = 2,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic [CS_W-1:0]  pattern_i,
    input  logic             mask_load_i,
    input  logic [CS_W-1:0]  mask_i,
    input  logic [DIV_W-1:0] prescale_i,
    output logic [CS_W-1:0]  cs_pin_o,
    output logic             done_o
);
    localparam int CNT_W = DLY_W + DIV_W + 1;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             upd;
    logic [CS_W-1:0]  upd_val;

    cs_seq_fsm #(
        .CS_W(CS_W), .DLY_W(DLY_W), .DIV_W(DIV_W), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_i), .delay_i(delay_i), .pattern_i(pattern_i),
        .prescale_i(prescale_i), .tmr_expired_i(tmr_expired),
        .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
        .upd_o(upd), .upd_val_o(upd_val), .done_o(done_o)
    );

    cs_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load_i(tmr_load), .load_val_i(tmr_val), .expired_o(tmr_expired)
    );

    cs_pin_stage #(.CS_W(CS_W)) u_pins (
        .clk(clk), .rst_n(rst_n),
        .upd_i(upd), .upd_val_i(upd_val),
        .mask_load_i(mask_load_i), .mask_i(mask_i),
        .pins_o(cs_pin_o)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cs_pin_o == '1 && !done_o));
endmodule

// File: tb/cs_timing_ctrl_bench.sv
module cs_timing_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] delay_i = '0;
    logic [7:0] pattern_i = '1;
    logic       mask_load_i = 1'b0;
    logic [7:0] mask_i = '0;
    logic [7:0] prescale_i = '0;
    logic [7:0] cs_pin_o;
    logic       done_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit running = 1'b0;
    bit finished = 1'b0;

    // scoreboard: kind 0 = pin change, kind 1 = done pulse
    int        q_kind[$];
    int        q_cyc[$];
    int        q_val[$];
    string     q_tag[$];
    logic [7:0] exp_log = 8'hFF;
    logic [7:0] exp_mask = 8'h00;
    logic [7:0] exp_pins = 8'hFF;
    logic [7:0] prev_pins = 8'hFF;

    cs_timing_ctrl u_cs_timing_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .delay_i(delay_i),
        .pattern_i(pattern_i), .mask_load_i(mask_load_i), .mask_i(mask_i),
        .prescale_i(prescale_i), .cs_pin_o(cs_pin_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic push_ev(int kind, int at, int val, string tag);
        q_kind.push_back(kind);
        q_cyc.push_back(at);
        q_val.push_back(val);
        q_tag.push_back(tag);
    endtask

    task automatic push_pins(int at, string tag);
        logic [7:0] np;
        np = exp_log ^ exp_mask;
        if (np != exp_pins) push_ev(0, at, int'(np), tag);
        exp_pins = np;
    endtask

    task automatic observe(int kind, int val);
        int ek, ec, ev;
        string et;
        checks++;
        if (q_kind.size() == 0) begin
            errors++;
            $display("FAIL unexpected event kind=%0d at cycle %0d val=%02h (R7 R9): actual event, expected none",
                     kind, cyc, val);
            return;
        end
        ek = q_kind.pop_front();
        ec = q_cyc.pop_front();
        ev = q_val.pop_front();
        et = q_tag.pop_front();
        if (ek != kind || ec != cyc || (kind == 0 && ev != val)) begin
            errors++;
            $display("FAIL %s: actual kind=%0d cycle=%0d val=%02h, expected kind=%0d cycle=%0d val=%02h",
                     et, kind, cyc, val, ek, ec, ev);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && running) begin
            if (cs_pin_o !== prev_pins) begin
                observe(0, int'(cs_pin_o));
                prev_pins = cs_pin_o;
            end
            if (done_o) observe(1, 0);
        end
    end

    task automatic drain();
        int k = 0;
        while (q_kind.size() != 0 && k < 5000) begin
            @(negedge clk);
            k++;
        end
        while (q_kind.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL %s: actual no event, expected kind=%0d at cycle %0d val=%02h",
                     q_tag[0], q_kind[0], q_cyc[0], q_val[0]);
            void'(q_kind.pop_front());
            void'(q_cyc.pop_front());
            void'(q_val.pop_front());
            void'(q_tag.pop_front());
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic run_cs(int t, int dv, logic [7:0] pat, string tag);
        int n, span;
        @(negedge clk);
        n = cyc + 1;
        span = t * (dv + 1) * 2;
        start_i = 1'b1;
        delay_i = 2'(t);
        prescale_i = 8'(dv);
        pattern_i = pat;
        exp_log = pat;
        push_pins(n + 2 + span, tag);
        push_ev(1, n + 2 + 2 * span, 0, tag);
        @(negedge clk);
        start_i = 1'b0;
        drain();
    endtask

    task automatic load_mask(logic [7:0] m, string tag);
        @(negedge clk);
        mask_load_i = 1'b1;
        mask_i = m;
        exp_mask = m;
        push_pins(cyc + 1, tag);
        @(negedge clk);
        mask_load_i = 1'b0;
        drain();
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (cs_pin_o !== 8'hFF || done_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: actual pins=%02h done=%b, expected pins=ff done=0", cs_pin_o, done_o);
        end
        running = 1'b1;

        // R2 R3 R4: zero span, update and done together
        run_cs(0, 0, 8'hFE, "R2 R4 t0");
        run_cs(1, 0, 8'hFD, "R3 R4 t1 div0");
        run_cs(3, 2, 8'h7F, "R3 R4 t3 div2");
        run_cs(0, 1, 8'hFE, "R2 restore");

        // R5: mask examples on logical 0xFE
        load_mask(8'hFF, "R5 mask ff");
        load_mask(8'h00, "R5 mask 00");
        load_mask(8'h01, "R5 mask 01");

        // R6 R7 R8: mask load, second start and prescaler change while busy
        @(negedge clk);
        n = cyc + 1;
        start_i = 1'b1;
        delay_i = 2'd1;
        prescale_i = 8'd3;
        pattern_i = 8'h3C;
        exp_mask = 8'h0F;
        push_pins(n + 5, "R6 mask while busy");
        exp_log = 8'h3C;
        push_pins(n + 10, "R6 R8 update through new mask");
        push_ev(1, n + 18, 0, "R7 R8 done timing");
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        start_i = 1'b1;
        delay_i = 2'd3;
        prescale_i = 8'd0;
        pattern_i = 8'h00;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        mask_load_i = 1'b1;
        mask_i = 8'h0F;
        @(negedge clk);
        mask_load_i = 1'b0;
        drain();

        load_mask(8'h00, "R6 clear mask");
        // R3 R4: largest prescaler
        run_cs(2, 255, 8'hAA, "R3 R4 div255");
        // R4 R9: same pattern, done only
        run_cs(1, 1, 8'hAA, "R4 R9 no pin change");

        running = 1'b0;
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule